// File: doc/BRIEF.md
# Single-Step ADC Sequencer Control

This block is the register-mapped front end of one sample sequencer that sits in front of an analog-to-digital converter. Software configures a channel number and a four-bit step control word, enables the sequencer, and then starts a conversion by writing a start bit. The block qualifies that start, presents a conversion request with the channel and the step options to an abstract converter port, and waits for the converter to return a 12-bit result.

Each returned result goes into a small result FIFO that software reads word by word. Completion is signalled through a raw status bit that software polls and clears by writing a one. The same bit, gated by a mask bit, drives an interrupt line. A step whose end marker is clear makes the sequencer launch the next conversion by itself for as long as it stays enabled.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset no conversion is requested, `irq` is 0, and the enable, trigger, channel, step, mask and status registers read as zero.
- R2: A start (a write to START at 0x10 with bit 3 set) launches a conversion only when bit 3 of ENABLE (0x00) is 1 and bits 15:12 of TRIGSEL (0x04) are zero. Otherwise `conv_req` stays 0.
- R3: While a conversion is pending, `conv_req` is 1 and stays 1 until `conv_done`. It carries `conv_chan` = CHAN (0x08) bits 3:0, `conv_diff` = STEP (0x0C) bit 0 and `conv_temp` = STEP bit 3, all captured at launch and held stable.
- R4: A start that arrives while a conversion is pending is ignored, so no extra conversion results from it.
- R5: Each completed conversion is stored in the FIFO. A read of RESULT (0x20) pops the entries in arrival order and returns the result in bits 11:0, with bits 31:12 zero.
- R6: On completion with STEP bit 2 (notify) set, STATUS (0x14) bit 3 becomes 1. It stays 1 until a write to CLEAR (0x1C) with bit 3 set. With STEP bit 2 clear it stays 0.
- R7: `irq` is 1 exactly when STATUS bit 3 and MASK (0x18) bit 3 are both 1. With the mask at 0, the status bit can still be polled.
- R8: With STEP bit 1 (last step) clear, each completion launches the next conversion while ENABLE bit 3 is 1. Clearing ENABLE lets the pending conversion finish, and no further conversion follows. With STEP bit 1 set, the sequencer stops after one result.
- R9: A read of an empty FIFO returns the last value popped and sets the sticky STATUS bit 9. A result that arrives while the FIFO is full is dropped and sets the sticky STATUS bit 8. Both bits are cleared by writing 1 to the same bit position in CLEAR.
- R10: ENABLE reads back only bit 3, TRIGSEL only bits 15:12, and CHAN, STEP and MASK only their defined bits. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RESULT) |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| conv_req | output | 1 | Conversion pending request |
| conv_chan | output | 4 | Channel of the pending conversion |
| conv_diff | output | 1 | Differential mode of the pending conversion |
| conv_temp | output | 1 | Temperature source select of the pending conversion |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_data | input | 12 | Conversion result, valid with `conv_done` |
| irq | output | 1 | Masked completion interrupt |

## Verification
The start path is tried with the sequencer disabled, with a non-zero trigger select, correctly armed, and re-armed while a conversion is still pending. This tells a proper qualifier apart from one that ignores either condition or accepts a second start. Single-step runs with notify set and clear, and with the mode bits set, separate the status logic from the FIFO path and confirm that the step options reach the converter. A free-running sequence without the last-step marker fills the FIFO past its depth and is then stopped by disabling. This shows the automatic relaunch, the drop-on-full with its sticky flag, the arrival order of the kept results, and the empty-read behaviour.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ADDR_W = 6;
  localparam int BUS_W  = 32;

  localparam logic [ADDR_W-1:0] A_ENABLE = 6'h00;
  localparam logic [ADDR_W-1:0] A_TRIG   = 6'h04;
  localparam logic [ADDR_W-1:0] A_CHAN   = 6'h08;
  localparam logic [ADDR_W-1:0] A_STEP   = 6'h0C;
  localparam logic [ADDR_W-1:0] A_START  = 6'h10;
  localparam logic [ADDR_W-1:0] A_STATUS = 6'h14;
  localparam logic [ADDR_W-1:0] A_MASK   = 6'h18;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 6'h1C;
  localparam logic [ADDR_W-1:0] A_RESULT = 6'h20;

  localparam int SEQ_BIT   = 3;
  localparam int OVF_BIT   = 8;
  localparam int UNF_BIT   = 9;
  localparam int TRIG_LO   = 12;

  typedef struct packed {
    logic temp;
    logic notify;
    logic last;
    logic diff;
  } step_ctl_t;
endpackage

// File: rtl/adc_seq_rstsync.sv
module adc_seq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic              en_bit,
  output logic [3:0]        trig_sel,
  output logic [CHAN_W-1:0] chan_sel,
  output step_ctl_t         step_ctl,
  output logic              mask_bit,
  output logic              start_hit
);
  logic              en_d, mask_d;
  logic [3:0]        trig_d;
  logic [CHAN_W-1:0] chan_d;
  step_ctl_t         step_d;
  logic              we_en, we_trig, we_chan, we_step, we_mask;

  always_comb begin
    we_en   = bus_wr && (bus_addr == A_ENABLE);
    we_trig = bus_wr && (bus_addr == A_TRIG);
    we_chan = bus_wr && (bus_addr == A_CHAN);
    we_step = bus_wr && (bus_addr == A_STEP);
    we_mask = bus_wr && (bus_addr == A_MASK);
    start_hit = bus_wr && (bus_addr == A_START) && bus_wdata[SEQ_BIT];
    en_d   = we_en   ? bus_wdata[SEQ_BIT]              : en_bit;
    trig_d = we_trig ? bus_wdata[TRIG_LO+3:TRIG_LO]    : trig_sel;
    chan_d = we_chan ? bus_wdata[CHAN_W-1:0]           : chan_sel;
    step_d = we_step ? step_ctl_t'(bus_wdata[3:0])     : step_ctl;
    mask_d = we_mask ? bus_wdata[SEQ_BIT]              : mask_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_bit   <= 1'b0;
      trig_sel <= '0;
      chan_sel <= '0;
      step_ctl <= '0;
      mask_bit <= 1'b0;
    end else begin
      en_bit   <= en_d;
      trig_sel <= trig_d;
      chan_sel <= chan_d;
      step_ctl <= step_d;
      mask_bit <= mask_d;
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_bit,
  input  logic [3:0]        trig_sel,
  input  logic [CHAN_W-1:0] chan_sel,
  input  step_ctl_t         step_ctl,
  input  logic              start_hit,
  input  logic              conv_done,
  output logic              busy,
  output logic [CHAN_W-1:0] cur_chan,
  output step_ctl_t         cur_step,
  output logic              done_hit
);
  logic              launch, relaunch, busy_d, cap_en;
  logic [CHAN_W-1:0] chan_d;
  step_ctl_t         step_d;

  always_comb begin
    launch   = start_hit && en_bit && (trig_sel == 4'd0) && !busy;
    done_hit = busy && conv_done;
    relaunch = done_hit && !cur_step.last && en_bit;
    busy_d   = launch || relaunch || (busy && !conv_done);
    cap_en   = launch;
    chan_d   = cap_en ? chan_sel : cur_chan;
    step_d   = cap_en ? step_ctl : cur_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_chan <= '0;
      cur_step <= '0;
    end else begin
      busy     <= busy_d;
      cur_chan <= chan_d;
      cur_step <= step_d;
    end
  end
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic              overflow,
  output logic              underflow,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_ptr_d, rd_ptr_d;
  logic [CNT_W-1:0]  count_d;
  logic [DATA_W-1:0] last_q, last_d;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full      = (count == CNT_W'(DEPTH));
    empty     = (count == '0);
    do_push   = push && !full;
    do_pop    = pop_req && !empty;
    overflow  = push && full;
    underflow = pop_req && empty;
    wr_ptr_d  = do_push ? ptr_inc(wr_ptr) : wr_ptr;
    rd_ptr_d  = do_pop  ? ptr_inc(rd_ptr) : rd_ptr;
    count_d   = count + CNT_W'(do_push) - CNT_W'(do_pop);
    last_d    = do_pop ? mem[rd_ptr] : last_q;
    rd_data   = empty ? last_q : mem[rd_ptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      last_q <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
      last_q <= last_d;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (do_push && (wr_ptr == PTR_W'(i))) mem[i] <= push_data;
      end
    end
  endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int CHAN_W     = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              conv_req,
  output logic [3:0]        conv_chan,
  output logic              conv_diff,
  output logic              conv_temp,
  input  logic              conv_done,
  input  logic [11:0]       conv_data,
  output logic              irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic              rst_n_i;
  logic              en_bit, mask_bit, start_hit, busy, done_hit;
  logic [3:0]        trig_sel;
  logic [CHAN_W-1:0] chan_sel, cur_chan;
  step_ctl_t         step_ctl, cur_step;
  logic [DATA_W-1:0] fifo_rd;
  logic              fifo_full, fifo_empty, ovf_evt, unf_evt, pop_req;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              raw_q, ovf_q, unf_q, raw_d, ovf_d, unf_d, clr_wr;

  adc_seq_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  adc_seq_regs #(.CHAN_W(CHAN_W)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en_bit(en_bit), .trig_sel(trig_sel),
    .chan_sel(chan_sel), .step_ctl(step_ctl), .mask_bit(mask_bit),
    .start_hit(start_hit)
  );

  adc_seq_fsm #(.CHAN_W(CHAN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_i), .en_bit(en_bit), .trig_sel(trig_sel),
    .chan_sel(chan_sel), .step_ctl(step_ctl), .start_hit(start_hit),
    .conv_done(conv_done), .busy(busy), .cur_chan(cur_chan),
    .cur_step(cur_step), .done_hit(done_hit)
  );

  assign pop_req = bus_rd && (bus_addr == A_RESULT);

  adc_seq_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n_i), .push(done_hit), .push_data(conv_data[DATA_W-1:0]),
    .pop_req(pop_req), .rd_data(fifo_rd), .full(fifo_full), .empty(fifo_empty),
    .overflow(ovf_evt), .underflow(unf_evt), .count(fifo_cnt)
  );

  always_comb begin
    clr_wr = bus_wr && (bus_addr == A_CLEAR);
    raw_d  = (done_hit && cur_step.notify) ||
             (raw_q && !(clr_wr && bus_wdata[SEQ_BIT]));
    ovf_d  = ovf_evt || (ovf_q && !(clr_wr && bus_wdata[OVF_BIT]));
    unf_d  = unf_evt || (unf_q && !(clr_wr && bus_wdata[UNF_BIT]));
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      raw_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_ENABLE: bus_rdata[SEQ_BIT] = en_bit;
        A_TRIG:   bus_rdata[TRIG_LO+3:TRIG_LO] = trig_sel;
        A_CHAN:   bus_rdata[CHAN_W-1:0] = chan_sel;
        A_STEP:   bus_rdata[3:0] = step_ctl;
        A_STATUS: begin
          bus_rdata[SEQ_BIT] = raw_q;
          bus_rdata[OVF_BIT] = ovf_q;
          bus_rdata[UNF_BIT] = unf_q;
        end
        A_MASK:   bus_rdata[SEQ_BIT] = mask_bit;
        A_RESULT: bus_rdata[DATA_W-1:0] = fifo_rd;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign conv_req  = busy;
  assign conv_chan = 4'(cur_chan);
  assign conv_diff = cur_step.diff;
  assign conv_temp = cur_step.temp;
  assign irq       = raw_q && mask_bit;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [5:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             conv_req,
  input logic             conv_done,
  input logic [3:0]       conv_chan,
  input logic             irq,
  input logic             raw,
  input logic             mask,
  input logic             en,
  input logic [CNT_W-1:0] fifo_cnt
);
  p_launch_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> en);

  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> conv_req);

  p_chan_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> $stable(conv_chan));

  p_raw_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !(bus_wr && bus_addr == 6'h1C && bus_wdata[3])) |=> raw);

  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
  .DEPTH(FIFO_DEPTH), .CNT_W($clog2(FIFO_DEPTH + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .conv_req(conv_req), .conv_done(conv_done),
  .conv_chan(conv_chan), .irq(irq), .raw(raw_q), .mask(mask_bit),
  .en(en_bit), .fifo_cnt(fifo_cnt)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int DEPTH = 4;
  localparam int LAT   = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        conv_req, conv_diff, conv_temp, conv_done, irq;
  logic [3:0]  conv_chan;
  logic [11:0] conv_data;

  int n_chk = 0, n_bad = 0, nconv = 0, exp_cnt = 0;
  logic [11:0] exp_q[$];
  logic [11:0] last_exp = '0;
  logic [7:0]  seq_n = '0;

  always #10 clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_diff(conv_diff),
    .conv_temp(conv_temp), .conv_done(conv_done), .conv_data(conv_data),
    .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read_result(input string req);
    logic [31:0] v;
    logic [11:0] e;
    rd(6'h20, v);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      exp_cnt--;
      last_exp = e;
    end else e = last_exp;
    check(v == {20'd0, e}, req, v, {20'd0, e});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!conv_req) break;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // converter model: acts as driver, pushing every kept result to the scoreboard
  initial begin
    conv_done = 1'b0; conv_data = '0;
    forever begin
      @(negedge clk);
      if (conv_req === 1'b1) begin
        repeat (LAT) @(negedge clk);
        seq_n++;
        conv_data = {conv_chan, seq_n};
        conv_done = 1'b1;
        nconv++;
        if (exp_cnt < DEPTH) begin
          exp_q.push_back({conv_chan, seq_n});
          exp_cnt++;
        end
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(conv_req == 1'b0, "R1 req", 32'(conv_req), 0);
    check(irq == 1'b0, "R1 irq", 32'(irq), 0);
    rd(6'h00, v); check(v == 0, "R1 enable", v, 0);
    rd(6'h14, v); check(v == 0, "R1 status", v, 0);
    rd(6'h08, v); check(v == 0, "R1 chan", v, 0);

    // R2 disabled start is ignored
    wr(6'h08, 32'd9);
    wr(6'h0C, 32'h6);
    wr(6'h10, 32'h8);
    repeat (4) @(negedge clk);
    check(conv_req == 1'b0 && nconv == 0, "R2 disabled", 32'(conv_req), 0);
    // R2 non-zero trigger select blocks software start
    wr(6'h04, 32'h5000);
    wr(6'h00, 32'h8);
    wr(6'h10, 32'h8);
    repeat (4) @(negedge clk);
    check(conv_req == 1'b0 && nconv == 0, "R2 trigger", 32'(conv_req), 0);
    wr(6'h04, 32'h0);

    // R3/R4 armed start, second start while pending
    wr(6'h10, 32'h8);
    check(conv_req == 1'b1, "R3 req", 32'(conv_req), 1);
    check(conv_chan == 4'd9 && !conv_diff && !conv_temp, "R3 chan",
          {28'd0, conv_chan}, 9);
    wr(6'h10, 32'h8);
    wait_idle();
    repeat (6) @(negedge clk);
    check(nconv == 1, "R4 single", nconv, 1);
    rd(6'h14, v); check(v == 32'h8, "R6 raw set", v, 32'h8);
    check(irq == 1'b0, "R7 masked", 32'(irq), 0);
    wr(6'h18, 32'h8);
    check(irq == 1'b1, "R7 unmasked", 32'(irq), 1);
    read_result("R5 first");
    read_result("R9 empty read");
    rd(6'h14, v); check(v == 32'h208, "R9 underflow", v, 32'h208);
    wr(6'h1C, 32'h308);
    rd(6'h14, v); check(v == 0, "R6 cleared", v, 0);
    check(irq == 1'b0, "R7 cleared", 32'(irq), 0);

    // R6 no notify
    wr(6'h0C, 32'h2);
    wr(6'h10, 32'h8);
    wait_idle();
    repeat (2) @(negedge clk);
    rd(6'h14, v); check(v == 0, "R6 no notify", v, 0);
    read_result("R5 second");

    // R3 mode bits reach converter
    wr(6'h08, 32'd11);
    wr(6'h0C, 32'hF);
    wr(6'h10, 32'h8);
    check(conv_chan == 4'd11 && conv_diff && conv_temp, "R3 modes",
          {26'd0, conv_diff, conv_temp, conv_chan}, {26'd0, 2'b11, 4'd11});
    wait_idle();
    repeat (2) @(negedge clk);
    read_result("R5 third");
    wr(6'h1C, 32'h8);

    // R8 free-running, R9 overflow
    n0 = nconv;
    wr(6'h08, 32'd3);
    wr(6'h0C, 32'h4);
    wr(6'h10, 32'h8);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (nconv >= n0 + 6) break;
    end
    wr(6'h00, 32'h0);
    wait_idle();
    repeat (8) @(negedge clk);
    check(conv_req == 1'b0, "R8 stopped", 32'(conv_req), 0);
    check(nconv >= n0 + 6, "R8 relaunch", nconv - n0, 6);
    rd(6'h14, v); check(v == 32'h108, "R9 overflow", v, 32'h108);
    for (int i = 0; i < DEPTH; i++) read_result("R5 order");
    read_result("R9 empty after drain");
    wr(6'h1C, 32'h308);
    rd(6'h14, v); check(v == 0, "R9 cleared", v, 0);

    // R10 readback masks
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, v); check(v == 32'hF000, "R10 trig", v, 32'hF000);
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, v); check(v == 32'hF, "R10 chan", v, 32'hF);
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, v); check(v == 32'h8, "R10 enable", v, 32'h8);
    rd(6'h18, v); check(v == 32'h8, "R10 mask", v, 32'h8);
    check(conv_req == 1'b0, "R2 trigger blocks", 32'(conv_req), 0);

    finish_run();
  end
endmodule